// File: doc/BRIEF.md
# Integer Multiply-Accumulate and Divide Unit

This block sits beside an integer pipeline and runs multiply and divide work on its own. The pipeline hands it two 32-bit operands and an operation code. The block keeps a 64-bit result pair, HI and LO. Plain multiplies overwrite the pair. Accumulating multiplies add their product to the pair, or subtract it, in one step. Divides leave the quotient in LO and the remainder in HI. One multiply variant skips the pair and writes the low half of its product to a general-register write port.

The block checks the operand size on its own. When both operands fit in 16 bits, a multiply finishes one cycle sooner and the next operation can issue one cycle sooner. A single stall output tells the pipeline when to wait. It is raised when an issue comes too soon, when HI or LO is read before its pending result has landed, and for the fixed stall cycles that the register-writing multiply imposes.

Top module: `muldiv_core`

## Requirements
- R1: After reset, HI and LO read as zero, the stall output is low with or without a read request, and the register write enable is low.
- R2: Op 0 (signed multiply) and op 1 (unsigned multiply) replace HI:LO with the full 64-bit product. A read of HI or LO is served without stall from cycle L after the issue cycle, where L is the latency from R3.
- R3: An operand is short when its bits 31:15 are all equal (signed ops: 0, 2, 4, 6, 7) or when its bits 31:16 are zero (unsigned ops: 1, 3, 5, 8). The multiply latency L is 3 when both operands are short and 4 otherwise. A read request stalls in cycles 1 to L-1 after the issue.
- R4: After a multiply is accepted, the next issue request stalls until R cycles have passed, with R = 2 for short operands and 3 otherwise. The request held into cycle R is accepted.
- R5: Op 2 (signed) and op 3 (unsigned) add the product to HI:LO. Op 4 (signed) and op 5 (unsigned) subtract the product from HI:LO. Back-to-back accumulates, each issued at the earliest allowed cycle, all take effect.
- R6: Op 6 (signed multiply to register) raises the register write enable for exactly one cycle, L-1 cycles after issue. That cycle carries the low 32 product bits and the destination index given at issue. HI and LO do not change.
- R7: Op 6 holds the stall output high, with no request present, for 1 cycle after issue when both operands are short and for 2 cycles otherwise.
- R8: Op 7 (signed divide) and op 8 (unsigned divide) put the truncated quotient in LO and the remainder in HI. The remainder takes the sign of the dividend. Latency and repeat interval are both 36 cycles.
- R9: A divide by zero still ends after 36 cycles. The stall on HI/LO reads is then released.
- R10: Op codes 9 to 15 are not accepted. They raise no stall and leave HI and LO unchanged.
- R11: HI and LO hold their values between results, and a read with no result pending is not stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid_i | input | 1 | Operation request; held while stall is high |
| issue_op_i | input | 4 | Operation code (see R2 to R10) |
| op_a_i | input | 32 | First operand / dividend |
| op_b_i | input | 32 | Second operand / divisor |
| issue_rd_i | input | 5 | Destination register index for op 6 |
| rd_hi_i | input | 1 | Pipeline wants HI this cycle |
| rd_lo_i | input | 1 | Pipeline wants LO this cycle |
| stall_o | output | 1 | Pipeline must hold this cycle |
| hi_o | output | 32 | HI value |
| lo_o | output | 32 | LO value |
| gpr_we_o | output | 1 | General-register write strobe |
| gpr_waddr_o | output | 5 | General-register write index |
| gpr_wdata_o | output | 32 | General-register write data |

## Verification
The assertions take for granted that the pipeline honours the stall. An issue request is never counted as accepted while the stall is high, so a new operation never lands on a running divide and a multiply never overwrites a pending result before it commits. The stimulus keeps within this: it holds each issue request until the stall drops, moves to the next operation only after acceptance, and raises read requests only while the issue request is low. A zero divisor appears only in the one directed case, because the result values for that case are left open.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

   typedef enum logic [3:0] {
      OP_MULT  = 4'd0,
      OP_MULTU = 4'd1,
      OP_MADD  = 4'd2,
      OP_MADDU = 4'd3,
      OP_MSUB  = 4'd4,
      OP_MSUBU = 4'd5,
      OP_MULR  = 4'd6,
      OP_DIV   = 4'd7,
      OP_DIVU  = 4'd8
   } md_op_e;

   // what the pending result does when it commits
   typedef enum logic [2:0] {
      K_NONE,
      K_SET,
      K_ADD,
      K_SUB,
      K_GPR,
      K_DIV
   } md_kind_e;

endpackage

// File: rtl/md_opsize.sv
// Flags an operation whose operands all fit in the short multiply path.
module md_opsize #(
   parameter int DW = 32
) (
   input  logic              signed_i,
   input  logic [DW/2:0]     top_a_i,   // operand bits DW-1 .. DW/2-1
   input  logic [DW/2:0]     top_b_i,
   output logic              short_o
);
   localparam int HW = DW / 2;

   logic [1:0]      fits;
   logic [HW:0]     tops [2];

   assign tops[0] = top_a_i;
   assign tops[1] = top_b_i;

   for (genvar g = 0; g < 2; g++) begin : g_opnd
      logic all_one, all_zero, upper_zero;
      assign all_one    = &tops[g];
      assign all_zero   = ~|tops[g];
      assign upper_zero = ~|tops[g][HW:1];
      assign fits[g]    = signed_i ? (all_one | all_zero) : upper_zero;
   end

   assign short_o = &fits;

endmodule

// File: rtl/md_mul_unit.sv
// Captures operands on load; the product is ready from the next cycle on.
module md_mul_unit #(
   parameter int DW = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_i,
   input  logic            signed_i,
   input  logic [DW-1:0]   a_i,
   input  logic [DW-1:0]   b_i,
   output logic [2*DW-1:0] prod_o
);
   logic [DW-1:0] a_q, b_q;
   logic          s_q;
   logic [2*DW-1:0] xa, xb;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_q <= '0;
         b_q <= '0;
         s_q <= 1'b0;
      end else if (load_i) begin
         a_q <= a_i;
         b_q <= b_i;
         s_q <= signed_i;
      end
   end

   // sign or zero extension lets one multiplier serve both flavours
   assign xa     = {{DW{s_q & a_q[DW-1]}}, a_q};
   assign xb     = {{DW{s_q & b_q[DW-1]}}, b_q};
   assign prod_o = xa * xb;

endmodule

// File: rtl/md_div_unit.sv
// Radix-2 restoring divider on magnitudes with a sign fix on the way out.
module md_div_unit #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          signed_i,
   input  logic [DW-1:0] dvd_i,
   input  logic [DW-1:0] dvs_i,
   output logic [DW-1:0] quo_o,
   output logic [DW-1:0] rem_o
);
   localparam int CNTW = $clog2(DW + 1);

   logic [CNTW-1:0] cnt_q;
   logic [DW-1:0]   quo_q, rem_q, dvs_q;
   logic            negq_q, negr_q;
   logic [DW:0]     rem_sh, diff;
   logic            take;

   function automatic logic [DW-1:0] mag(input logic [DW-1:0] v, input logic s);
      return (s && v[DW-1]) ? (~v + DW'(1)) : v;
   endfunction

   assign rem_sh = {rem_q, quo_q[DW-1]};
   assign diff   = rem_sh - {1'b0, dvs_q};
   assign take   = rem_sh[DW] | ~diff[DW];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         quo_q  <= '0;
         rem_q  <= '0;
         dvs_q  <= '0;
         negq_q <= 1'b0;
         negr_q <= 1'b0;
      end else if (start_i) begin
         cnt_q  <= CNTW'(DW);
         quo_q  <= mag(dvd_i, signed_i);
         rem_q  <= '0;
         dvs_q  <= mag(dvs_i, signed_i);
         negq_q <= signed_i & (dvd_i[DW-1] ^ dvs_i[DW-1]);
         negr_q <= signed_i & dvd_i[DW-1];
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CNTW'(1);
         rem_q <= take ? diff[DW-1:0] : rem_sh[DW-1:0];
         quo_q <= {quo_q[DW-2:0], take};
      end
   end

   assign quo_o = negq_q ? (~quo_q + DW'(1)) : quo_q;
   assign rem_o = negr_q ? (~rem_q + DW'(1)) : rem_q;

   // R8: a start always loads a full run of steps
   assert_div_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (cnt_q == CNTW'(DW)));

   // R9: once the step counter is spent the result stays put until a new start
   assert_div_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0 && !start_i) |=> ($stable(quo_q) && $stable(rem_q)));

endmodule

// File: rtl/muldiv_core.sv
module muldiv_core
   import muldiv_pkg::*;
#(
   parameter int DW          = 32,
   parameter int RW          = 5,
   parameter int LAT_SHORT   = 3,
   parameter int LAT_LONG    = 4,
   parameter int REP_SHORT   = 2,
   parameter int REP_LONG    = 3,
   parameter int STALL_SHORT = 1,
   parameter int STALL_LONG  = 2,
   parameter int DIV_LAT     = 36
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          issue_valid_i,
   input  logic [3:0]    issue_op_i,
   input  logic [DW-1:0] op_a_i,
   input  logic [DW-1:0] op_b_i,
   input  logic [RW-1:0] issue_rd_i,
   input  logic          rd_hi_i,
   input  logic          rd_lo_i,
   output logic          stall_o,
   output logic [DW-1:0] hi_o,
   output logic [DW-1:0] lo_o,
   output logic          gpr_we_o,
   output logic [RW-1:0] gpr_waddr_o,
   output logic [DW-1:0] gpr_wdata_o
);
   localparam int HW = DW / 2;
   localparam int CW = $clog2(DIV_LAT + 1);

   initial begin : p_param_chk
      assert (DW >= 8 && DW % 2 == 0) else $fatal(1, "DW must be even and at least 8");
      assert (LAT_SHORT >= 2 && LAT_LONG >= LAT_SHORT) else $fatal(1, "bad multiply latency");
      assert (REP_SHORT >= 2 && REP_SHORT >= LAT_SHORT - 1 && REP_SHORT <= LAT_SHORT)
         else $fatal(1, "short repeat must cover the single pending slot");
      assert (REP_LONG >= LAT_LONG - 1 && REP_LONG <= LAT_LONG)
         else $fatal(1, "long repeat must cover the single pending slot");
      assert (STALL_SHORT >= 1 && STALL_LONG >= STALL_SHORT && STALL_LONG <= REP_LONG)
         else $fatal(1, "bad forced stall counts");
      assert (DIV_LAT >= DW + 2) else $fatal(1, "divide latency too short for the step count");
   end

   // ---------------- decode ----------------
   md_kind_e dec_kind;
   logic     dec_signed, dec_short, is_div;

   always_comb begin
      dec_kind   = K_NONE;
      dec_signed = 1'b0;
      case (issue_op_i)
         OP_MULT:  begin dec_kind = K_SET; dec_signed = 1'b1; end
         OP_MULTU: begin dec_kind = K_SET; dec_signed = 1'b0; end
         OP_MADD:  begin dec_kind = K_ADD; dec_signed = 1'b1; end
         OP_MADDU: begin dec_kind = K_ADD; dec_signed = 1'b0; end
         OP_MSUB:  begin dec_kind = K_SUB; dec_signed = 1'b1; end
         OP_MSUBU: begin dec_kind = K_SUB; dec_signed = 1'b0; end
         OP_MULR:  begin dec_kind = K_GPR; dec_signed = 1'b1; end
         OP_DIV:   begin dec_kind = K_DIV; dec_signed = 1'b1; end
         OP_DIVU:  begin dec_kind = K_DIV; dec_signed = 1'b0; end
         default:  begin dec_kind = K_NONE; dec_signed = 1'b0; end
      endcase
   end

   assign is_div = (dec_kind == K_DIV);

   md_opsize #(.DW(DW)) u_size (
      .signed_i (dec_signed),
      .top_a_i  (op_a_i[DW-1:HW-1]),
      .top_b_i  (op_b_i[DW-1:HW-1]),
      .short_o  (dec_short)
   );

   logic [CW-1:0] lat_new, rep_new, frc_new;

   always_comb begin
      if (is_div) begin
         lat_new = CW'(DIV_LAT - 1);
         rep_new = CW'(DIV_LAT - 1);
      end else if (dec_short) begin
         lat_new = CW'(LAT_SHORT - 1);
         rep_new = CW'(REP_SHORT - 1);
      end else begin
         lat_new = CW'(LAT_LONG - 1);
         rep_new = CW'(REP_LONG - 1);
      end
      if (dec_kind == K_GPR)
         frc_new = dec_short ? CW'(STALL_SHORT) : CW'(STALL_LONG);
      else
         frc_new = '0;
   end

   // ---------------- scoreboard ----------------
   logic [CW-1:0] lat_cnt, rep_cnt, frc_cnt;
   md_kind_e      pend_kind;
   logic [RW-1:0] pend_rd;
   logic          pend_hilo, commit, accept;
   logic          stall_issue, stall_read, stall_force;

   assign pend_hilo   = (pend_kind != K_NONE) && (pend_kind != K_GPR);
   assign stall_issue = issue_valid_i && (dec_kind != K_NONE) && (rep_cnt != '0);
   assign stall_read  = (rd_hi_i || rd_lo_i) && (lat_cnt != '0) && pend_hilo;
   assign stall_force = (frc_cnt != '0);
   assign stall_o     = stall_issue | stall_read | stall_force;
   assign accept      = issue_valid_i && (dec_kind != K_NONE) && !stall_o;
   assign commit      = (lat_cnt == CW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lat_cnt   <= '0;
         rep_cnt   <= '0;
         frc_cnt   <= '0;
         pend_kind <= K_NONE;
         pend_rd   <= '0;
      end else begin
         if (accept) begin
            lat_cnt   <= lat_new;
            rep_cnt   <= rep_new;
            frc_cnt   <= frc_new;
            pend_kind <= dec_kind;
            pend_rd   <= issue_rd_i;
         end else begin
            if (lat_cnt != '0) lat_cnt <= lat_cnt - CW'(1);
            if (rep_cnt != '0) rep_cnt <= rep_cnt - CW'(1);
            if (frc_cnt != '0) frc_cnt <= frc_cnt - CW'(1);
            if (commit)        pend_kind <= K_NONE;
         end
      end
   end

   // ---------------- datapath ----------------
   logic [2*DW-1:0] prod;
   logic [DW-1:0]   div_quo, div_rem;

   md_mul_unit #(.DW(DW)) u_mul (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (accept && !is_div),
      .signed_i (dec_signed),
      .a_i      (op_a_i),
      .b_i      (op_b_i),
      .prod_o   (prod)
   );

   md_div_unit #(.DW(DW)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (accept && is_div),
      .signed_i (dec_signed),
      .dvd_i    (op_a_i),
      .dvs_i    (op_b_i),
      .quo_o    (div_quo),
      .rem_o    (div_rem)
   );

   logic [DW-1:0]   hi_q, lo_q;
   logic [2*DW-1:0] acc_nx;

   always_comb begin
      case (pend_kind)
         K_SET:   acc_nx = prod;
         K_ADD:   acc_nx = {hi_q, lo_q} + prod;
         K_SUB:   acc_nx = {hi_q, lo_q} - prod;
         K_DIV:   acc_nx = {div_rem, div_quo};
         default: acc_nx = {hi_q, lo_q};
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_q <= '0;
         lo_q <= '0;
      end else if (commit) begin
         {hi_q, lo_q} <= acc_nx;
      end
   end

   assign hi_o        = hi_q;
   assign lo_o        = lo_q;
   assign gpr_we_o    = commit && (pend_kind == K_GPR);
   assign gpr_waddr_o = pend_rd;
   assign gpr_wdata_o = prod[DW-1:0];

   // ---------------- checks ----------------
   // R4: two accepts never land on neighbouring cycles
   assert_issue_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !accept);

   // R7: a register-writing multiply stalls the pipeline in the cycle after issue
   assert_force_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && dec_kind == K_GPR) |=> stall_o);

   // R6: the register write strobe is a single-cycle pulse
   assert_gpr_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      gpr_we_o |=> !gpr_we_o);

   // R11: HI and LO move only on a commit
   assert_hilo_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> ($stable(hi_q) && $stable(lo_q)));

   // R6: a register write leaves HI and LO untouched
   assert_gpr_keeps_hilo_R6: assert property (@(posedge clk) disable iff (!rst_n)
      gpr_we_o |=> ($stable(hi_q) && $stable(lo_q)));

endmodule

// File: tb/muldiv_core_tb.sv
module muldiv_core_tb;
   import muldiv_pkg::*;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        issue_valid;
   logic [3:0]  issue_op;
   logic [31:0] op_a, op_b;
   logic [4:0]  issue_rd;
   logic        rd_hi, rd_lo;
   logic        stall;
   logic [31:0] hi, lo;
   logic        gpr_we;
   logic [4:0]  gpr_waddr;
   logic [31:0] gpr_wdata;

   int n_chk = 0;
   int n_err = 0;
   logic [63:0] m_hilo;

   always #(CLK_PERIOD / 2) clk = ~clk;

   muldiv_core u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .issue_valid_i (issue_valid),
      .issue_op_i    (issue_op),
      .op_a_i        (op_a),
      .op_b_i        (op_b),
      .issue_rd_i    (issue_rd),
      .rd_hi_i       (rd_hi),
      .rd_lo_i       (rd_lo),
      .stall_o       (stall),
      .hi_o          (hi),
      .lo_o          (lo),
      .gpr_we_o      (gpr_we),
      .gpr_waddr_o   (gpr_waddr),
      .gpr_wdata_o   (gpr_wdata)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   // ---------- reference model from the requirements ----------
   function automatic bit op_signed(input logic [3:0] op);
      return (op == 4'd0 || op == 4'd2 || op == 4'd4 || op == 4'd6 || op == 4'd7);
   endfunction

   function automatic bit fits16(input logic [31:0] v, input bit s);
      if (s) return (v[31:15] == 17'h0) || (v[31:15] == 17'h1FFFF);
      return v[31:16] == 16'h0;
   endfunction

   function automatic bit both_short(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
      return fits16(a, op_signed(op)) && fits16(b, op_signed(op));
   endfunction

   function automatic int lat_of(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
      if (op == 4'd7 || op == 4'd8) return 36;
      return both_short(op, a, b) ? 3 : 4;
   endfunction

   function automatic int rep_of(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
      if (op == 4'd7 || op == 4'd8) return 36;
      return both_short(op, a, b) ? 2 : 3;
   endfunction

   function automatic logic [63:0] product(input bit s, input logic [31:0] a, input logic [31:0] b);
      logic [63:0] xa, xb;
      xa = s ? {{32{a[31]}}, a} : {32'h0, a};
      xb = s ? {{32{b[31]}}, b} : {32'h0, b};
      return xa * xb;
   endfunction

   function automatic logic [63:0] divide(input bit s, input logic [31:0] a, input logic [31:0] b);
      longint x, y, q, r;
      x = s ? longint'($signed(a)) : longint'({32'h0, a});
      y = s ? longint'($signed(b)) : longint'({32'h0, b});
      q = x / y;
      r = x % y;
      return {r[31:0], q[31:0]};
   endfunction

   function automatic logic [63:0] model_next(input logic [3:0] op, input logic [31:0] a,
                                              input logic [31:0] b, input logic [63:0] cur);
      case (op)
         4'd0, 4'd1: return product(op_signed(op), a, b);
         4'd2, 4'd3: return cur + product(op_signed(op), a, b);
         4'd4, 4'd5: return cur - product(op_signed(op), a, b);
         4'd7, 4'd8: return divide(op_signed(op), a, b);
         default:    return cur;
      endcase
   endfunction

   // ---------- stimulus helpers ----------
   // issue from an idle state; returns in cycle 1 after acceptance
   task automatic do_issue(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                           input logic [4:0] rd, input string tag);
      issue_valid = 1'b1;
      issue_op    = op;
      op_a        = a;
      op_b        = b;
      issue_rd    = rd;
      #3;
      chk({tag, " issue not stalled"}, {63'h0, stall}, 64'h0);
      tick();
      issue_valid = 1'b0;
   endtask

   // called in cycle 1; read requests held through cycle lat
   task automatic wait_result(input int lat, input logic [63:0] exp, input string tag);
      rd_hi = 1'b1;
      rd_lo = 1'b1;
      for (int k = 1; k <= lat; k++) begin
         #3;
         if (k == 1 || k >= lat - 1)
            chk({tag, " read stall"}, {63'h0, stall}, {63'h0, (k < lat)});
         if (k == lat) begin
            chk({tag, " HI"}, {32'h0, hi}, {32'h0, exp[63:32]});
            chk({tag, " LO"}, {32'h0, lo}, {32'h0, exp[31:0]});
         end
         tick();
      end
      rd_hi = 1'b0;
      rd_lo = 1'b0;
   endtask

   // called in cycle 1 of a pending op; holds a second request until accepted
   task automatic issue_follow(input int rep, input logic [3:0] op, input logic [31:0] a,
                               input logic [31:0] b, input string tag);
      issue_valid = 1'b1;
      issue_op    = op;
      op_a        = a;
      op_b        = b;
      for (int k = 1; k <= rep; k++) begin
         #3;
         chk({tag, " repeat stall"}, {63'h0, stall}, {63'h0, (k < rep)});
         tick();
      end
      issue_valid = 1'b0;
   endtask

   task automatic run_op(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         input string tag);
      do_issue(op, a, b, 5'd0, tag);
      m_hilo = model_next(op, a, b, m_hilo);
      wait_result(lat_of(op, a, b), m_hilo, tag);
   endtask

   task automatic run_mulr(input logic [31:0] a, input logic [31:0] b, input logic [4:0] rd,
                           input string tag);
      int lat, frc;
      logic [63:0] p;
      lat = lat_of(4'd6, a, b);
      frc = both_short(4'd6, a, b) ? 1 : 2;
      p   = product(1'b1, a, b);
      do_issue(4'd6, a, b, rd, tag);
      for (int k = 1; k <= lat; k++) begin
         #3;
         chk({tag, " R7 forced stall"}, {63'h0, stall}, {63'h0, (k <= frc)});
         chk({tag, " R6 write strobe"}, {63'h0, gpr_we}, {63'h0, (k == lat - 1)});
         if (k == lat - 1) begin
            chk({tag, " R6 write index"}, {59'h0, gpr_waddr}, {59'h0, rd});
            chk({tag, " R6 write data"}, {32'h0, gpr_wdata}, {32'h0, p[31:0]});
         end
         tick();
      end
      #3;
      chk({tag, " R6 HI:LO untouched"}, {hi, lo}, m_hilo);
      tick();
   endtask

   function automatic logic [31:0] pick_operand(input int mode);
      logic [31:0] r;
      r = $urandom;
      case (mode)
         0: return {{16{r[15]}}, r[15:0]};
         1: return {16'h0, r[15:0]};
         2: return r;
         default: begin
            case (r[2:0])
               3'd0:    return 32'h8000_0000;
               3'd1:    return 32'hFFFF_FFFF;
               3'd2:    return 32'h0000_7FFF;
               3'd3:    return 32'hFFFF_8000;
               3'd4:    return 32'h0000_8000;
               3'd5:    return 32'h7FFF_FFFF;
               default: return 32'h0000_0001;
            endcase
         end
      endcase
   endfunction

   // ---------- watchdog ----------
   initial begin : p_watchdog
      repeat (150000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL R2 watchdog actual=timeout expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   // ---------- main sequence ----------
   initial begin : p_main
      logic [3:0] ops [8];
      ops = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd7, 4'd8};
      void'($urandom(32'd20240611));
      rst_n = 1'b0;
      issue_valid = 1'b0;
      issue_op = 4'd0;
      op_a = '0;
      op_b = '0;
      issue_rd = '0;
      rd_hi = 1'b0;
      rd_lo = 1'b0;
      m_hilo = '0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // R1 reset state
      rd_hi = 1'b1;
      #3;
      chk("R1 HI after reset", {32'h0, hi}, 64'h0);
      chk("R1 LO after reset", {32'h0, lo}, 64'h0);
      chk("R1 stall with read", {63'h0, stall}, 64'h0);
      chk("R1 write strobe", {63'h0, gpr_we}, 64'h0);
      tick();
      rd_hi = 1'b0;

      // R2 / R3 size boundaries
      run_op(4'd0, 32'h0000_7FFF, 32'h0000_0002, "R2 R3 signed short");
      run_op(4'd0, 32'h0000_8000, 32'h0000_0002, "R2 R3 signed long at bit 15");
      run_op(4'd0, 32'hFFFF_8000, 32'hFFFF_FFFF, "R2 R3 signed negative short");
      run_op(4'd1, 32'h0000_FFFF, 32'h0000_FFFF, "R2 R3 unsigned short");
      run_op(4'd1, 32'h0001_0000, 32'h0000_0003, "R2 R3 unsigned long");
      run_op(4'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 unsigned max");

      // R4 / R5 back-to-back accumulates
      do_issue(4'd2, 32'h1234_5678, 32'h9ABC_DEF0, 5'd0, "R5 madd long");
      m_hilo = model_next(4'd2, 32'h1234_5678, 32'h9ABC_DEF0, m_hilo);
      issue_follow(3, 4'd2, 32'h0000_0005, 32'hFFFF_FFF9, "R4 R5 madd after long");
      m_hilo = model_next(4'd2, 32'h0000_0005, 32'hFFFF_FFF9, m_hilo);
      issue_follow(2, 4'd5, 32'h0000_1000, 32'h0000_0300, "R4 R5 msubu after short");
      m_hilo = model_next(4'd5, 32'h0000_1000, 32'h0000_0300, m_hilo);
      wait_result(3, m_hilo, "R5 accumulate chain");
      run_op(4'd4, 32'h8000_0000, 32'h8000_0000, "R5 msub extreme");
      run_op(4'd3, 32'hFFFF_FFFF, 32'h0000_0002, "R5 maddu");

      // R6 / R7 multiply to register
      run_mulr(32'h0000_0123, 32'hFFFF_FFFE, 5'd7, "R6 R7 short");
      run_mulr(32'h0012_3456, 32'h0000_0100, 5'd31, "R6 R7 long");

      // R8 divide
      run_op(4'd7, 32'hFFFF_FFF9, 32'h0000_0002, "R8 signed negative dividend");
      run_op(4'd7, 32'h0000_0007, 32'hFFFF_FFFE, "R8 signed negative divisor");
      run_op(4'd8, 32'hFFFF_FFFF, 32'h0000_0010, "R8 unsigned");
      run_op(4'd7, 32'h8000_0000, 32'hFFFF_FFFF, "R8 most negative by minus one");

      // R8 repeat interval of a divide
      do_issue(4'd8, 32'd1000, 32'd7, 5'd0, "R8 divide repeat");
      m_hilo = model_next(4'd8, 32'd1000, 32'd7, m_hilo);
      issue_follow(36, 4'd0, 32'd3, 32'd4, "R8 issue after divide");
      m_hilo = model_next(4'd0, 32'd3, 32'd4, m_hilo);
      wait_result(3, m_hilo, "R8 follow-up multiply");

      // R9 divide by zero ends in time
      do_issue(4'd7, 32'h0000_1234, 32'h0, 5'd0, "R9 divide by zero");
      rd_lo = 1'b1;
      for (int k = 1; k <= 36; k++) begin
         #3;
         if (k == 1 || k >= 35)
            chk("R9 stall window", {63'h0, stall}, {63'h0, (k < 36)});
         tick();
      end
      rd_lo = 1'b0;
      m_hilo = {hi, lo};

      // R10 undefined codes
      for (int c = 9; c <= 15; c += 3) begin
         issue_valid = 1'b1;
         issue_op    = 4'(c);
         op_a        = 32'h1111_1111;
         op_b        = 32'h2222_2222;
         #3;
         chk("R10 no stall on undefined op", {63'h0, stall}, 64'h0);
         tick();
         issue_valid = 1'b0;
         rd_hi = 1'b1;
         #3;
         chk("R10 read not stalled", {63'h0, stall}, 64'h0);
         chk("R10 HI:LO unchanged", {hi, lo}, m_hilo);
         tick();
         rd_hi = 1'b0;
      end

      // R11 idle hold
      repeat (5) tick();
      rd_lo = 1'b1;
      #3;
      chk("R11 idle read not stalled", {63'h0, stall}, 64'h0);
      chk("R11 HI:LO held", {hi, lo}, m_hilo);
      tick();
      rd_lo = 1'b0;

      // random mix, R2 R3 R5 R8
      for (int i = 0; i < 60; i++) begin
         logic [3:0]  op;
         logic [31:0] a, b;
         op = ops[$urandom % 8];
         a  = pick_operand(int'($urandom % 4));
         b  = pick_operand(int'($urandom % 4));
         if ((op == 4'd7 || op == 4'd8) && b == 32'h0) b = 32'h3;
         run_op(op, a, b, "R2 R5 R8 random");
      end

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule